// File: doc/BRIEF.md
# Frames Out Of Sync Counter

This block is the per-second performance counter that sits behind the receive framer of a T1/E1 line interface. It counts one of two quantities, chosen by a count-mode control bit and the line mode. The first is the number of multiframes during which the framer's synchronizer has lost alignment. The second is the number of framing-pattern errors. In T1 SF framing these are terminal framing bit errors. In T1 ESF framing they are framing pattern sequence errors. In E1 they are frame alignment word errors in timeslot 0.

The framer supplies single-cycle strobes for multiframe boundaries and for each kind of framing error. It also supplies a loss-of-frame level and an alignment-search level. A one-second strobe moves the running accumulator into a held output register and restarts the accumulation, so software-facing logic reads a stable per-second figure. The live accumulator is also brought out.

Which events are counted, and when loss of frame or alignment search blocks them, depends on the mode. In out-of-sync counting, loss of frame is the condition being measured, so it does not block counting. In error counting, errors seen while the frame is lost are meaningless and are dropped.

Top module: `frames_oos_counter`

## Requirements
- R1: After synchronous reset, both `count_q` and `acc_live` read 0.
- R2: With `line_mode` T1 SF (2'b00) or T1 ESF (2'b01) and `cnt_mos`=1, each cycle with `mf_strobe`=1 and `lof`=1 adds one to the accumulator. A `mf_strobe` while `lof`=0 adds nothing.
- R3: In T1 out-of-sync counting (`cnt_mos`=1), `ft_err`, `fps_err` and `fas_err` have no effect on the accumulator.
- R4: With `line_mode`=2'b00 (T1 SF) and `cnt_mos`=0, each `ft_err` pulse adds one while `lof`=0. `fps_err` and `mf_strobe` are ignored.
- R5: With `line_mode`=2'b01 (T1 ESF) and `cnt_mos`=0, each `fps_err` pulse adds one while `lof`=0. `ft_err` and `mf_strobe` are ignored.
- R6: In the framing-error modes (T1 with `cnt_mos`=0, or E1), no event is counted while `lof`=1.
- R7: With `line_mode[1]`=1 (E1, 2'b10 or 2'b11), each `fas_err` pulse adds one while `lof`=0 and `align_search`=0. `cnt_mos`, `mf_strobe`, `ft_err` and `fps_err` are ignored.
- R8: In E1, `fas_err` is ignored while `align_search`=1.
- R9: In a cycle with `sec_tick`=1, `count_q` takes the accumulator value from before that edge. The accumulator restarts at 1 if that cycle also holds a counted event, otherwise at 0.
- R10: The 16-bit accumulator saturates at 16'hFFFF and holds there until the next `sec_tick`.
- R11: `count_q` changes only on a `sec_tick` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_mode | input | 2 | 00 T1 SF, 01 T1 ESF, 1x E1 |
| cnt_mos | input | 1 | 1: count multiframes out of sync (T1 only), 0: count framing errors |
| mf_strobe | input | 1 | Multiframe boundary pulse |
| lof | input | 1 | Loss of frame level |
| ft_err | input | 1 | Terminal framing bit error pulse (T1 SF) |
| fps_err | input | 1 | Framing pattern sequence error pulse (T1 ESF) |
| fas_err | input | 1 | E1 frame alignment word error pulse |
| align_search | input | 1 | E1 framer searching for FAS or multiframe alignment |
| sec_tick | input | 1 | One-second latch strobe |
| count_q | output | 16 | Count latched at the last one-second strobe |
| acc_live | output | 16 | Running accumulator |

## Verification
A wrong event qualification or a wrong accumulator step shows on `acc_live` on the clock edge that follows the stimulus, and one `sec_tick` later on `count_q`. A wrong latch or clear shows on both outputs one edge after the strobe. The bench compares both outputs against its own model every cycle. A divergence is therefore reported in the cycle it first appears, and stuck saturation or clearing bugs are exposed by directed runs across the limit and across strobes.

// File: rtl/fos_pkg.sv
package fos_pkg;

    parameter int ACC_W = 16;

    typedef enum logic [1:0] {
        LM_T1_SF  = 2'b00,
        LM_T1_ESF = 2'b01,
        LM_E1     = 2'b10,
        LM_E1_ALT = 2'b11
    } line_mode_e;

    typedef struct packed {
        logic mf;
        logic lof;
        logic ft;
        logic fps;
        logic fas;
        logic search;
    } fos_evt_t;

    function automatic logic is_e1(input logic [1:0] lm);
        return lm[1];
    endfunction

    function automatic logic is_esf(input logic [1:0] lm);
        return (lm == LM_T1_ESF);
    endfunction

endpackage

// File: rtl/fos_event_sel.sv
module fos_event_sel
    import fos_pkg::*;
(
    input  logic [1:0] line_mode,
    input  logic       cnt_mos,
    input  fos_evt_t   evt,
    output logic       inc
);

    logic t1_mos_hit;
    logic t1_bit_hit;
    logic e1_fas_hit;

    always_comb begin
        t1_mos_hit = evt.mf & evt.lof;
        t1_bit_hit = ~evt.lof & (is_esf(line_mode) ? evt.fps : evt.ft);
        e1_fas_hit = ~evt.lof & ~evt.search & evt.fas;
        if (is_e1(line_mode))
            inc = e1_fas_hit;
        else if (cnt_mos)
            inc = t1_mos_hit;
        else
            inc = t1_bit_hit;
    end

endmodule

// File: rtl/fos_accum.sv
module fos_accum
    import fos_pkg::*;
#(
    parameter int W = ACC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    input  logic         tick,
    output logic [W-1:0] acc
);

    localparam logic [W-1:0] ACC_MAX = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst)
            acc <= '0;
        else if (tick)
            acc <= {{(W-1){1'b0}}, inc};
        else if (inc && acc != ACC_MAX)
            acc <= acc + 1'b1;
    end

    a_r10_sat_hold: assert property (@(posedge clk) disable iff (rst)
        (acc == ACC_MAX && !tick) |=> (acc == ACC_MAX));

    a_r9_tick_restart: assert property (@(posedge clk) disable iff (rst)
        tick |=> (acc <= {{(W-1){1'b0}}, 1'b1}));

    a_r10_step_one: assert property (@(posedge clk) disable iff (rst)
        !tick |=> (acc == $past(acc) || acc == $past(acc) + 1'b1));

endmodule

// File: rtl/fos_latch.sv
module fos_latch
    import fos_pkg::*;
#(
    parameter int W = ACC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [W-1:0] acc,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (tick)
            q <= acc;
    end

    a_r9_latch_value: assert property (@(posedge clk) disable iff (rst)
        tick |=> (q == $past(acc)));

    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(q));

endmodule

// File: rtl/frames_oos_counter.sv
module frames_oos_counter
    import fos_pkg::*;
#(
    parameter int W = ACC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   line_mode,
    input  logic         cnt_mos,
    input  logic         mf_strobe,
    input  logic         lof,
    input  logic         ft_err,
    input  logic         fps_err,
    input  logic         fas_err,
    input  logic         align_search,
    input  logic         sec_tick,
    output logic [W-1:0] count_q,
    output logic [W-1:0] acc_live
);

    fos_evt_t evt;
    logic     inc;

    always_comb begin
        evt.mf     = mf_strobe;
        evt.lof    = lof;
        evt.ft     = ft_err;
        evt.fps    = fps_err;
        evt.fas    = fas_err;
        evt.search = align_search;
    end

    fos_event_sel u_sel (
        .line_mode (line_mode),
        .cnt_mos   (cnt_mos),
        .evt       (evt),
        .inc       (inc)
    );

    fos_accum #(.W(W)) u_acc (
        .clk  (clk),
        .rst  (rst),
        .inc  (inc),
        .tick (sec_tick),
        .acc  (acc_live)
    );

    fos_latch #(.W(W)) u_latch (
        .clk  (clk),
        .rst  (rst),
        .tick (sec_tick),
        .acc  (acc_live),
        .q    (count_q)
    );

    a_r6_lof_blocks_errors: assert property (@(posedge clk) disable iff (rst)
        (lof && (line_mode[1] || !cnt_mos) && !sec_tick) |=> $stable(acc_live));

    a_r8_search_blocks: assert property (@(posedge clk) disable iff (rst)
        (line_mode[1] && align_search && !sec_tick) |=> $stable(acc_live));

    a_r2_mos_counts: assert property (@(posedge clk) disable iff (rst)
        (!line_mode[1] && cnt_mos && mf_strobe && lof && !sec_tick
         && acc_live != {W{1'b1}}) |=> (acc_live == $past(acc_live) + 1'b1));

    a_r3_mos_no_lof: assert property (@(posedge clk) disable iff (rst)
        (!line_mode[1] && cnt_mos && !lof && !sec_tick) |=> $stable(acc_live));

endmodule

// File: tb/frames_oos_counter_tb_top.sv
module frames_oos_counter_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  line_mode;
    logic        cnt_mos, mf_strobe, lof, ft_err, fps_err, fas_err, align_search, sec_tick;
    logic [15:0] count_q, acc_live;

    int checks = 0;
    int failures = 0;
    logic [15:0] exp_acc = '0;
    logic [15:0] exp_q = '0;

    always #4 clk = ~clk;

    frames_oos_counter dut_i (
        .clk(clk), .rst(rst), .line_mode(line_mode), .cnt_mos(cnt_mos),
        .mf_strobe(mf_strobe), .lof(lof), .ft_err(ft_err), .fps_err(fps_err),
        .fas_err(fas_err), .align_search(align_search), .sec_tick(sec_tick),
        .count_q(count_q), .acc_live(acc_live)
    );

    function automatic bit model_inc(input logic [1:0] lm, input bit mos, input bit mf,
                                     input bit lf, input bit ft, input bit fps,
                                     input bit fas, input bit srch);
        if (lm[1])   return fas && !lf && !srch;
        if (mos)     return mf && lf;
        if (lm == 2'b01) return fps && !lf;
        return ft && !lf;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic [1:0] lm, input bit mos, input bit mf, input bit lf,
                       input bit ft, input bit fps, input bit fas, input bit srch,
                       input bit tk, input string req);
        bit i;
        @(negedge clk);
        line_mode = lm; cnt_mos = mos; mf_strobe = mf; lof = lf; ft_err = ft;
        fps_err = fps; fas_err = fas; align_search = srch; sec_tick = tk;
        i = model_inc(lm, mos, mf, lf, ft, fps, fas, srch);
        if (tk) begin
            exp_q = exp_acc;
            exp_acc = {15'd0, i};
        end else if (i && exp_acc != 16'hFFFF) begin
            exp_acc = exp_acc + 16'd1;
        end
        @(posedge clk);
        #1;
        check({req, " acc"}, acc_live, exp_acc);
        check({req, " q"}, count_q, exp_q);
    endtask

    initial begin
        #1600000;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1;
        line_mode = 2'b00; cnt_mos = 0; mf_strobe = 0; lof = 0; ft_err = 0;
        fps_err = 0; fas_err = 0; align_search = 0; sec_tick = 0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 acc", acc_live, 16'h0);
        check("R1 q", count_q, 16'h0);
        @(negedge clk);
        rst = 1'b0;

        // R2 / R3: T1 SF out-of-sync counting
        for (int k = 0; k < 3; k++) cyc(2'b00, 1, 1, 1, 1, 1, 1, 0, 0, "R2");
        for (int k = 0; k < 2; k++) cyc(2'b00, 1, 1, 0, 0, 0, 0, 0, 0, "R2");
        for (int k = 0; k < 3; k++) cyc(2'b01, 1, 0, 1, 1, 1, 1, 0, 0, "R3");
        cyc(2'b01, 1, 1, 1, 0, 0, 0, 0, 0, "R2");
        check("R2 total", acc_live, 16'd4);
        cyc(2'b00, 1, 0, 0, 0, 0, 0, 0, 1, "R9");
        check("R9 latched", count_q, 16'd4);

        // R4 / R6: SF framing-bit mode
        for (int k = 0; k < 4; k++) cyc(2'b00, 0, 1, 0, 1, 1, 1, 0, 0, "R4");
        for (int k = 0; k < 2; k++) cyc(2'b00, 0, 1, 0, 0, 1, 1, 0, 0, "R4");
        for (int k = 0; k < 2; k++) cyc(2'b00, 0, 1, 1, 1, 0, 0, 0, 0, "R6");
        check("R4 total", acc_live, 16'd4);

        // R5 / R6: ESF framing-bit mode
        for (int k = 0; k < 3; k++) cyc(2'b01, 0, 1, 0, 0, 1, 0, 0, 0, "R5");
        for (int k = 0; k < 2; k++) cyc(2'b01, 0, 0, 0, 1, 0, 1, 0, 0, "R5");
        cyc(2'b01, 0, 0, 1, 0, 1, 0, 0, 0, "R6");

        // R9: tick together with a counted event
        cyc(2'b01, 0, 0, 0, 0, 1, 0, 0, 1, "R9");
        check("R9 restart", acc_live, 16'd1);
        check("R9 latch", count_q, 16'd7);

        // R7 / R8 / R6: E1
        for (int k = 0; k < 3; k++) cyc(2'b10, 1, 1, 1, 1, 1, 0, 0, 0, "R7");
        for (int k = 0; k < 3; k++) cyc(2'b11, 1, 1, 0, 1, 1, 1, 0, 0, "R7");
        for (int k = 0; k < 2; k++) cyc(2'b10, 0, 0, 0, 0, 0, 1, 1, 0, "R8");
        for (int k = 0; k < 2; k++) cyc(2'b10, 0, 0, 1, 0, 0, 1, 0, 0, "R6");
        check("R7 total", acc_live, 16'd4);

        // R11: hold without tick
        for (int k = 0; k < 5; k++) cyc(2'b10, 0, 0, 0, 0, 0, 1, 0, 0, "R11");
        check("R11 hold", count_q, 16'd7);

        // R10: saturation
        cyc(2'b10, 0, 0, 0, 0, 0, 0, 0, 1, "R9");
        for (int k = 0; k < 65540; k++) cyc(2'b10, 0, 0, 0, 0, 0, 1, 0, 0, "R10");
        check("R10 saturated", acc_live, 16'hFFFF);
        cyc(2'b10, 0, 0, 0, 0, 0, 0, 0, 1, "R10");
        check("R10 latched", count_q, 16'hFFFF);
        check("R10 cleared", acc_live, 16'h0);

        // constrained random mix
        for (int k = 0; k < 4000; k++) begin
            cyc(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                1'($urandom_range(0, 1)), ($urandom_range(0, 3) == 0),
                1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                1'($urandom_range(0, 1)), ($urandom_range(0, 3) == 0),
                ($urandom_range(0, 99) == 0), "RND");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule